// File: doc/BRIEF.md
# MDIO Management Command Controller

This block lets a host reach PHY management registers through four small registers instead of bit-banging. The host first writes a setup register to enable the interface and choose the management clock rate. For a write it also loads a write-data register. A single store to the command register then holds the PHY address, the register address, the opcode and an initiate bit. That store launches one complete clause-22 serial transaction on MDC/MDIO.

On a read, the controller releases the data line from the turnaround onward and samples sixteen bits on MDC rising edges. It places the result in a read-data register. If no PHY pulls the line low in the second turnaround slot, the result is forced to all ones, so an absent device reads as 0xFFFF. While a transaction runs, the ready bit in the command register readback is low, and further command stores are dropped. A one-cycle done pulse marks the end of every transaction.

Register selection uses a 2-bit index:
- 0 is setup.
- 1 is command.
- 2 is write data.
- 3 is read data, which is read-only.

Reads are combinational on `reg_rdata`.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset, MDC and the MDIO output enable are low, and setup and read data read as 0. The command readback is 0x00000080, with only ready (bit 7) set.
- R2: A setup write stores only bits 6:0 and the upper bits read back as zero. Bit 6 is the interface enable and bits 5:0 are the clock divider.
- R3: `cfg_err` is high exactly while the interface is enabled with a divider of zero.
- R4: The command word places the PHY address in bits 28:24, the register address in 20:16 and the opcode in 15:14, with initiate at bit 11. A command store with initiate set, the interface enabled and a valid opcode starts a frame. Ready (command readback bit 7) is low from the next cycle until the frame ends.
- R5: Opcode 1 (write) sends the following bits, MSB first on each falling MDC edge: 32 ones, 01, 01, the PHY address, the register address, 10, then the 16-bit write data.
- R6: Opcode 2 (read) sends 32 ones, 01, 10 and both addresses. It then releases MDIO for the two turnaround bits and the 16 data bits. Data is sampled on MDC rising edges, MSB first, into read data (readback index 3, bits 15:0).
- R7: If MDIO is high when sampled in the second turnaround bit of a read, read data becomes 0xFFFF.
- R8: Opcodes 0 and 3 start no frame: ready stays high, MDC stays low and read data is unchanged.
- R9: A command store while a frame runs is ignored. The readback keeps the earlier command, and no extra frame follows.
- R10: Each MDC half period lasts divider+1 system clocks.
- R11: `done` is high for exactly one cycle at the end of each frame.
- R12: A command with initiate clear, or any command while the interface is disabled, starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index (0 setup, 1 command, 2 write data, 3 read data) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register readback of `reg_addr` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data driven value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data line as seen at the pad |
| cfg_err | output | 1 | Enabled with zero divider |
| done | output | 1 | One-cycle pulse at frame end |

## Verification
A behavioural PHY in the bench decodes each frame bit by bit. Its checks cover the following faults:
- A controller that swaps the opcode or turnaround pattern leaves the PHY registers untouched, and the captured frame differs.
- One that keeps driving MDIO after the address fields, or that samples on the wrong MDC edge, returns shifted or corrupted read data.
- A PHY that sends data but never pulls the turnaround low must still yield 0xFFFF. A design that only looks at the data bits would return that data instead.

Further stimulus issues a command mid-frame, uses opcodes 0 and 3, and clears initiate. A controller that re-launches in any of these cases shows extra MDC pulses and a changed command readback. Measuring the MDC period at two dividers exposes an off-by-one in the divider.

// File: rtl/mdio_cmd_pkg.sv
package mdio_cmd_pkg;

    // Field widths fixed by the clause-22 frame and the command word layout
    localparam int PHY_W  = 5;
    localparam int REG_W  = 5;
    localparam int DATA_W = 16;
    localparam int SETUP_W = 7;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_RSVD  = 2'b11
    } mdio_op_e;

    typedef enum logic [1:0] {
        IDX_SETUP = 2'd0,
        IDX_CMD   = 2'd1,
        IDX_WDATA = 2'd2,
        IDX_RDATA = 2'd3
    } reg_idx_e;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;

    // One tick every div+1 clocks while a frame runs
    always_comb begin
        cnt_d = cnt_q;
        tick  = 1'b0;
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q >= div) begin
            cnt_d = '0;
            tick  = 1'b1;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame #(
    parameter int PRE_LEN = 32,
    parameter int DATA_W  = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic                         is_rd,
    input  logic [PRE_LEN+16+DATA_W-1:0] frame_in,
    input  logic                         tick,
    input  logic                         mdio_i,
    output logic                         busy,
    output logic                         mdc,
    output logic                         mdio_o,
    output logic                         mdio_oe,
    output logic                         done,
    output logic [DATA_W-1:0]            rd_data,
    output logic                         phy_seen
);
    localparam int FRAME_W = PRE_LEN + 16 + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam logic [CNT_W-1:0] TA1_IDX  = CNT_W'(PRE_LEN + 14);
    localparam logic [CNT_W-1:0] TA2_IDX  = CNT_W'(PRE_LEN + 15);
    localparam logic [CNT_W-1:0] DAT_IDX  = CNT_W'(PRE_LEN + 16);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

    typedef struct packed {
        logic               busy;
        logic               mdc;
        logic               rd;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] sh;
        logic [DATA_W-1:0]  cap;
        logic               ta_low;
        logic               done;
    } frm_t;

    frm_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (start && !q.busy) begin
            d.busy   = 1'b1;
            d.mdc    = 1'b0;
            d.rd     = is_rd;
            d.cnt    = '0;
            d.sh     = frame_in;
            d.cap    = '0;
            d.ta_low = 1'b0;
        end else if (q.busy && tick) begin
            if (!q.mdc) begin
                // rising edge: PHY-driven bits are sampled here
                d.mdc = 1'b1;
                if (q.rd && q.cnt == TA2_IDX) d.ta_low = !mdio_i;
                if (q.rd && q.cnt >= DAT_IDX) d.cap = {q.cap[DATA_W-2:0], mdio_i};
            end else begin
                // falling edge: advance to the next bit
                d.mdc = 1'b0;
                d.sh  = {q.sh[FRAME_W-2:0], 1'b1};
                if (q.cnt == LAST_IDX) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign busy     = q.busy;
    assign mdc      = q.mdc;
    assign mdio_o   = q.sh[FRAME_W-1];
    assign mdio_oe  = q.busy && (!q.rd || q.cnt < TA1_IDX);
    assign done     = q.done;
    assign rd_data  = q.cap;
    assign phy_seen = q.ta_low;

    // R10: MDC only moves on a divider tick
    a_r10_mdc_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && !tick) |=> $stable(q.mdc));
    // R1: MDC rests low between frames
    a_r1_idle_mdc_low: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |-> !q.mdc);
    // R6: the line is released mid-frame only on reads
    a_r6_release_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && $fell(mdio_oe)) |-> q.rd);
    // R11: done lasts one cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
    import mdio_cmd_pkg::*;
#(
    parameter int PRE_LEN = 32,
    parameter int DIV_W   = 6
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i,
    output logic        cfg_err,
    output logic        done
);
    localparam int FRAME_W = PRE_LEN + 16 + DATA_W;
    localparam int EN_BIT  = DIV_W;

    typedef struct packed {
        logic [SETUP_W-1:0] setup;
        logic [31:0]        cmd;
        logic [DATA_W-1:0]  wdata;
        logic [DATA_W-1:0]  rdata;
    } regs_t;

    regs_t d, q;

    logic               start, busy, tick, phy_seen, is_rd;
    logic [DATA_W-1:0]  cap_data;
    logic [FRAME_W-1:0] frame_word;
    mdio_op_e           new_op;
    logic               en;
    logic [DIV_W-1:0]   div;

    assign en     = q.setup[EN_BIT];
    assign div    = q.setup[DIV_W-1:0];
    assign new_op = mdio_op_e'(reg_wdata[15:14]);
    assign is_rd  = (new_op == OP_READ);

    always_comb begin
        frame_word = {{PRE_LEN{1'b1}}, 2'b01, reg_wdata[15:14],
                      reg_wdata[28:24], reg_wdata[20:16],
                      (is_rd ? 2'b11 : 2'b10),
                      (is_rd ? {DATA_W{1'b1}} : q.wdata)};
    end

    always_comb begin
        d     = q;
        start = 1'b0;
        if (reg_wr) begin
            case (reg_idx_e'(reg_addr))
                IDX_SETUP: d.setup = reg_wdata[SETUP_W-1:0];
                IDX_CMD: begin
                    if (!busy) begin
                        d.cmd = {reg_wdata[31:8], 1'b0, reg_wdata[6:0]};
                        if (reg_wdata[11] && en &&
                            (new_op == OP_WRITE || new_op == OP_READ))
                            start = 1'b1;
                    end
                end
                IDX_WDATA: d.wdata = reg_wdata[DATA_W-1:0];
                default: ;
            endcase
        end
        if (done && mdio_op_e'(q.cmd[15:14]) == OP_READ)
            d.rdata = phy_seen ? cap_data : {DATA_W{1'b1}};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (reg_idx_e'(reg_addr))
            IDX_SETUP: reg_rdata = {{(32-SETUP_W){1'b0}}, q.setup};
            IDX_CMD:   reg_rdata = q.cmd | {24'd0, !busy, 7'd0};
            IDX_WDATA: reg_rdata = {{(32-DATA_W){1'b0}}, q.wdata};
            default:   reg_rdata = {{(32-DATA_W){1'b0}}, q.rdata};
        endcase
    end

    assign cfg_err = en && (div == '0);

    mdio_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (div),
        .tick  (tick)
    );

    mdio_frame #(.PRE_LEN(PRE_LEN), .DATA_W(DATA_W)) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .is_rd    (is_rd),
        .frame_in (frame_word),
        .tick     (tick),
        .mdio_i   (mdio_i),
        .busy     (busy),
        .mdc      (mdc),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .done     (done),
        .rd_data  (cap_data),
        .phy_seen (phy_seen)
    );

    // R4: an accepted command makes the engine busy
    a_r4_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    // R9: command stores during a frame leave the command register alone
    a_r9_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == IDX_CMD && busy) |=> $stable(q.cmd));
    // R8: reserved opcodes never launch a frame
    a_r8_badop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == IDX_CMD && !busy &&
         (reg_wdata[15:14] == 2'b00 || reg_wdata[15:14] == 2'b11)) |=> !busy);
    // R7: a silent turnaround yields all ones
    a_r7_absent_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (done && q.cmd[15:14] == 2'b10 && !phy_seen) |=> (q.rdata == {DATA_W{1'b1}}));

endmodule

// File: tb/tb_mdio_cmd_ctrl.sv
module tb_mdio_cmd_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam logic [4:0] PHY_ADDR = 5'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i, cfg_err, done;

    int n_chk = 0;
    int n_fail = 0;

    // behavioural PHY state
    logic        drv = 1'b1;
    logic        ta_fail = 1'b0;
    logic        rd_active = 1'b0;
    logic [15:0] rd_word = 16'd0;
    logic [63:0] cap_sh = 64'd0;
    logic [63:0] last_frame = 64'd0;
    logic [15:0] phy_regs [32];
    int          n_pos = 0;
    int          done_cnt = 0;
    longint      t_prev = 0;
    int          mdc_period = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : drv;

    mdio_cmd_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
        .cfg_err(cfg_err), .done(done)
    );

    always @(negedge clk) if (done) done_cnt++;

    always @(posedge mdc) begin
        logic [63:0] s;
        s = {cap_sh[62:0], mdio_i};
        cap_sh = s;
        if (n_pos % 64 == 63) begin
            last_frame = s;
            if (s[29:28] == 2'b01 && s[27:23] == PHY_ADDR)
                phy_regs[s[22:18]] = s[15:0];
        end
        n_pos = n_pos + 1;
        mdc_period = int'(($time - t_prev) / CLK_PERIOD);
        t_prev = $time;
    end

    always @(negedge mdc) begin
        int k;
        k = n_pos % 64;
        drv = 1'b1;
        if (k == 47) begin
            rd_active = (cap_sh[12:11] == 2'b10) && (cap_sh[10:6] == PHY_ADDR);
            rd_word   = phy_regs[cap_sh[5:1]];
            if (rd_active && !ta_fail) drv = 1'b0;
        end else if (k >= 48 && rd_active) begin
            drv = rd_word[63-k];
        end else if (k == 0) begin
            rd_active = 1'b0;
        end
    end

    function automatic logic [31:0] mk_cmd(input logic [4:0] phy, input logic [4:0] rg,
                                           input logic [1:0] op, input logic init);
        return {3'b0, phy, 3'b0, rg, op, 2'b0, init, 11'b0};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [31:0] v);
        @(negedge clk);
        reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [31:0] v);
        @(negedge clk);
        reg_addr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 20000; i++) begin
            rd_reg(2'd1, v);
            if (v[7]) break;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 mdc", {63'd0, mdc}, 64'd0);
        check("R1 oe", {63'd0, mdio_oe}, 64'd0);
        rd_reg(2'd0, v); check("R1 setup", {32'd0, v}, 64'd0);
        rd_reg(2'd1, v); check("R1 cmd ready", {32'd0, v}, 64'h80);
        rd_reg(2'd3, v); check("R1 rdata", {32'd0, v}, 64'd0);
    endtask

    task automatic t_setup();
        logic [31:0] v;
        wr_reg(2'd0, 32'hFFFF_FFC3);
        rd_reg(2'd0, v); check("R2 setup mask", {32'd0, v}, 64'h43);
        check("R3 no err", {63'd0, cfg_err}, 64'd0);
        wr_reg(2'd0, 32'h40);
        rd_reg(2'd0, v); check("R3 err flagged", {63'd0, cfg_err}, 64'd1);
        wr_reg(2'd0, 32'h00);
        rd_reg(2'd0, v); check("R3 err off when disabled", {63'd0, cfg_err}, 64'd0);
        wr_reg(2'd0, 32'h43);
    endtask

    task automatic t_write();
        logic [31:0] v;
        int d0;
        d0 = done_cnt;
        wr_reg(2'd2, 32'h0000_A5C3);
        wr_reg(2'd1, mk_cmd(5'd7, 5'd4, 2'b01, 1'b1));
        rd_reg(2'd1, v); check("R4 ready low", {63'd0, v[7]}, 64'd0);
        wait_idle();
        check("R5 write frame", last_frame,
              {32'hFFFF_FFFF, 2'b01, 2'b01, 5'd7, 5'd4, 2'b10, 16'hA5C3});
        check("R5 phy reg written", {48'd0, phy_regs[4]}, 64'hA5C3);
        check("R10 period div3", mdc_period, 64'd8);
        check("R11 one done", done_cnt - d0, 64'd1);
    endtask

    task automatic t_read();
        logic [31:0] v;
        phy_regs[9] = 16'h1234;
        wr_reg(2'd1, mk_cmd(5'd7, 5'd9, 2'b10, 1'b1));
        wait_idle();
        check("R6 read header", {18'd0, last_frame[63:18]},
              {18'd0, 32'hFFFF_FFFF, 2'b01, 2'b10, 5'd7, 5'd9});
        check("R6 turnaround", {62'd0, last_frame[17:16]}, 64'd2);
        rd_reg(2'd3, v); check("R6 rdata", {32'd0, v}, 64'h1234);
    endtask

    task automatic t_absent();
        logic [31:0] v;
        wr_reg(2'd1, mk_cmd(5'd3, 5'd9, 2'b10, 1'b1));
        wait_idle();
        rd_reg(2'd3, v); check("R7 absent phy", {32'd0, v}, 64'hFFFF);
        phy_regs[9] = 16'h0055;
        wr_reg(2'd1, mk_cmd(5'd7, 5'd9, 2'b10, 1'b1));
        wait_idle();
        rd_reg(2'd3, v); check("R7 baseline present", {32'd0, v}, 64'h0055);
        ta_fail = 1'b1;
        wr_reg(2'd1, mk_cmd(5'd7, 5'd9, 2'b10, 1'b1));
        wait_idle();
        ta_fail = 1'b0;
        rd_reg(2'd3, v); check("R7 silent turnaround", {32'd0, v}, 64'hFFFF);
    endtask

    task automatic t_badop();
        logic [31:0] v;
        int p0;
        p0 = n_pos;
        wr_reg(2'd1, mk_cmd(5'd7, 5'd9, 2'b00, 1'b1));
        repeat (30) @(negedge clk);
        rd_reg(2'd1, v); check("R8 op0 ready", {63'd0, v[7]}, 64'd1);
        wr_reg(2'd1, mk_cmd(5'd7, 5'd9, 2'b11, 1'b1));
        repeat (30) @(negedge clk);
        rd_reg(2'd1, v); check("R8 op3 stored", {32'd0, v}, {32'd0, mk_cmd(5'd7, 5'd9, 2'b11, 1'b1) | 32'h80});
        check("R8 no mdc", n_pos - p0, 64'd0);
        rd_reg(2'd3, v); check("R8 rdata kept", {32'd0, v}, 64'hFFFF);
    endtask

    task automatic t_busy();
        logic [31:0] v;
        int p0, d0;
        p0 = n_pos; d0 = done_cnt;
        wr_reg(2'd2, 32'h0F0F);
        wr_reg(2'd1, mk_cmd(5'd7, 5'd2, 2'b01, 1'b1));
        repeat (20) @(negedge clk);
        wr_reg(2'd1, mk_cmd(5'd7, 5'd9, 2'b10, 1'b1));
        rd_reg(2'd1, v); check("R9 cmd unchanged", {32'd0, v}, {32'd0, mk_cmd(5'd7, 5'd2, 2'b01, 1'b1)});
        wait_idle();
        repeat (300) @(negedge clk);
        check("R9 single frame", n_pos - p0, 64'd64);
        check("R9 write landed", {48'd0, phy_regs[2]}, 64'h0F0F);
        check("R11 single done", done_cnt - d0, 64'd1);
        rd_reg(2'd3, v); check("R9 rdata kept", {32'd0, v}, 64'hFFFF);
    endtask

    task automatic t_noinit();
        logic [31:0] v;
        int p0;
        p0 = n_pos;
        wr_reg(2'd1, mk_cmd(5'd7, 5'd9, 2'b10, 1'b0));
        repeat (30) @(negedge clk);
        check("R12 no initiate", n_pos - p0, 64'd0);
        wr_reg(2'd0, 32'h03);
        wr_reg(2'd1, mk_cmd(5'd7, 5'd9, 2'b01, 1'b1));
        repeat (30) @(negedge clk);
        rd_reg(2'd1, v); check("R12 disabled ready", {63'd0, v[7]}, 64'd1);
        check("R12 disabled no frame", n_pos - p0, 64'd0);
    endtask

    task automatic t_div();
        wr_reg(2'd0, 32'h41);
        wr_reg(2'd2, 32'h3C3C);
        wr_reg(2'd1, mk_cmd(5'd7, 5'd6, 2'b01, 1'b1));
        wait_idle();
        check("R10 period div1", mdc_period, 64'd4);
        check("R5 div1 write", {48'd0, phy_regs[6]}, 64'h3C3C);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) phy_regs[i] = 16'd0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_setup();
        t_write();
        t_read();
        t_absent();
        t_badop();
        t_busy();
        t_noinit();
        t_div();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule